// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a single-word-line, direct-mapped cache controller. Each line has a partner line whose index differs only in the top index bit, and the two lines form a pseudo-set. A read whose primary line matches is answered in the cycle the request first appears. On a primary miss the controller probes the partner line in the next cycle. A match there is a slow hit, and the two lines then trade places so that the same address hits fast the next time. If both probes miss, the word is fetched from lower-level memory and installed in the primary line. The previous primary occupant drops into the partner line.

Writes are write-through and never allocate. A write that matches either line of its pseudo-set updates that line in place. Every write is also forwarded to memory, and the CPU is released when memory acknowledges.

The CPU side is a hold-until-ready request port: `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stay stable until `cpu_ready` pulses for one cycle. The memory side uses the same discipline, with `mem_ack` as the one-cycle completion.

The controller has four states:
- `ST_IDLE` probes the primary line. It takes the transition *fast hit* (back to `ST_IDLE`), *write hit* (to `ST_WRITE`) or *primary miss* (to `ST_ALT`).
- `ST_ALT` probes the partner line. It takes the transition *slow hit with swap* (to `ST_IDLE`), *write forward* (to `ST_WRITE`) or *double miss* (to `ST_FETCH`).
- `ST_FETCH` waits for the memory read. It takes *fill* (to `ST_IDLE`) on `mem_ack`.
- `ST_WRITE` waits for the memory write. It takes *write done* (to `ST_IDLE`) on `mem_ack`.

Top module: `pa_cache`

## Requirements
- R1: Reset clears every valid bit and leaves `cpu_ready` and `mem_req` low; the first read of any address after reset is a full miss.
- R2: A read whose primary line (index = the low log2(LINES) bits of the word address) holds the block raises `cpu_ready` with the block's data in the first cycle of the request, with no memory traffic.
- R3: On a primary miss the line at the index with its top bit inverted is probed in the following cycle; a read match there raises `cpu_ready` in the second cycle with that line's data.
- R4: After a read slow hit the two lines of the pseudo-set are exchanged: an immediate repeat of that address hits in 1 cycle, and the displaced block becomes a slow hit.
- R5: A read that misses both lines issues exactly one memory read, no earlier than the third cycle of the request; `cpu_ready` rises in the cycle `mem_ack` arrives, carrying the memory word.
- R6: A fill writes the fetched block into the primary line; a valid previous primary occupant moves to the partner line and evicts it, while an invalid primary leaves the partner line untouched.
- R7: Each stored tag is the word address above the index plus the index top bit, so two blocks with equal upper address bits and different index top bits never match each other.
- R8: A write matching the primary line updates it, issues one memory write, and raises `cpu_ready` in the cycle of `mem_ack`; a later read hits in 1 cycle with the written data.
- R9: A write matching the partner line updates that line in place without exchanging lines; a later read is a slow hit returning the written data.
- R10: A write matching neither line performs only the memory write: no memory read and no allocation, so a later read is a full miss returning the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The assertions rely on two properties of the inputs. The CPU keeps its request and its fields steady from the cycle it raises `cpu_req` until the cycle `cpu_ready` is high. Memory pulses `mem_ack` for a single cycle, and only while `mem_req` is asserted. The request-age counter and the write-through checks rest on that hold discipline; a request that changed mid-flight would make the latency bounds meaningless. The directed stimulus sets up every access at a falling edge and removes it only after the rising edge that consumes `cpu_ready`. The memory model acknowledges after a fixed delay and drops `mem_ack` the following cycle.

// File: rtl/pa_cache_pkg.sv
package pa_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALT,
        ST_FETCH,
        ST_WRITE
    } pa_state_e;

    typedef enum logic [1:0] {
        LSRC_CPU,
        LSRC_MEM,
        LSRC_PRI,
        LSRC_ALT
    } line_src_e;

    typedef enum logic [1:0] {
        RSEL_PRI,
        RSEL_ALT,
        RSEL_MEM
    } rsel_e;

endpackage

// File: rtl/pa_index_map.sv
module pa_index_map #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  pri_idx,
    output logic [IDX_W-1:0]  alt_idx,
    output logic [TAG_W-1:0]  req_tag
);
    // Primary slot is the natural index; partner flips the index top bit.
    assign pri_idx = addr[IDX_W-1:0];
    assign alt_idx = {~addr[IDX_W-1], addr[IDX_W-2:0]};
    // The tag keeps the index top bit so a block is identifiable in either slot.
    assign req_tag = addr[ADDR_W-1:IDX_W-1];
endmodule

// File: rtl/pa_line_store.sv
module pa_line_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  pri_idx,
    input  logic [IDX_W-1:0]  alt_idx,
    output logic              pri_valid,
    output logic [TAG_W-1:0]  pri_tag,
    output logic [DATA_W-1:0] pri_data,
    output logic              alt_valid,
    output logic [TAG_W-1:0]  alt_tag,
    output logic [DATA_W-1:0] alt_data,
    input  logic              pri_we,
    input  logic              pri_wvalid,
    input  logic [TAG_W-1:0]  pri_wtag,
    input  logic [DATA_W-1:0] pri_wdata,
    input  logic              alt_we,
    input  logic              alt_wvalid,
    input  logic [TAG_W-1:0]  alt_wtag,
    input  logic [DATA_W-1:0] alt_wdata
);
    logic              valid_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    // Both slots of a pseudo-set can be rewritten in one edge (swap and fill).
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                data_q[i]  <= '0;
            end else if (pri_we && (pri_idx == IDX_W'(i))) begin
                valid_q[i] <= pri_wvalid;
                tag_q[i]   <= pri_wtag;
                data_q[i]  <= pri_wdata;
            end else if (alt_we && (alt_idx == IDX_W'(i))) begin
                valid_q[i] <= alt_wvalid;
                tag_q[i]   <= alt_wtag;
                data_q[i]  <= alt_wdata;
            end
        end
    end

    assign pri_valid = valid_q[pri_idx];
    assign pri_tag   = tag_q[pri_idx];
    assign pri_data  = data_q[pri_idx];
    assign alt_valid = valid_q[alt_idx];
    assign alt_tag   = tag_q[alt_idx];
    assign alt_data  = data_q[alt_idx];
endmodule

// File: rtl/pa_probe_fsm.sv
module pa_probe_fsm
    import pa_cache_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_req,
    input  logic      cpu_we,
    input  logic      probe_hit,
    input  logic      pri_valid,
    input  logic      mem_ack,
    output logic      sel_alt,
    output logic      cpu_ready,
    output rsel_e     rsel,
    output logic      pri_we,
    output line_src_e pri_src,
    output logic      alt_we,
    output line_src_e alt_src,
    output logic      mem_req,
    output logic      mem_we
);
    pa_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        sel_alt   = 1'b0;
        cpu_ready = 1'b0;
        rsel      = RSEL_PRI;
        pri_we    = 1'b0;
        pri_src   = LSRC_CPU;
        alt_we    = 1'b0;
        alt_src   = LSRC_CPU;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (probe_hit && cpu_we) begin          // write hit
                        pri_we = 1'b1;
                        nxt    = ST_WRITE;
                    end else if (probe_hit) begin           // fast hit
                        cpu_ready = 1'b1;
                    end else begin                          // primary miss
                        nxt = ST_ALT;
                    end
                end
            end
            ST_ALT: begin
                sel_alt = 1'b1;
                rsel    = RSEL_ALT;
                if (probe_hit && !cpu_we) begin             // slow hit with swap
                    cpu_ready = 1'b1;
                    pri_we    = 1'b1;
                    pri_src   = LSRC_ALT;
                    alt_we    = 1'b1;
                    alt_src   = LSRC_PRI;
                    nxt       = ST_IDLE;
                end else if (cpu_we) begin                  // write forward
                    alt_we = probe_hit;
                    nxt    = ST_WRITE;
                end else begin                              // double miss
                    nxt = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                rsel    = RSEL_MEM;
                if (mem_ack) begin                          // fill
                    cpu_ready = 1'b1;
                    pri_we    = 1'b1;
                    pri_src   = LSRC_MEM;
                    alt_we    = pri_valid;
                    alt_src   = LSRC_PRI;
                    nxt       = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                rsel    = RSEL_MEM;
                if (mem_ack) begin                          // write done
                    cpu_ready = 1'b1;
                    nxt       = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pa_cache.sv
module pa_cache
    import pa_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W + 1;

    logic [IDX_W-1:0]  pri_idx, alt_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              pri_valid, alt_valid;
    logic [TAG_W-1:0]  pri_tag, alt_tag;
    logic [DATA_W-1:0] pri_data, alt_data;
    logic              pri_we, alt_we;
    logic              pri_wvalid, alt_wvalid;
    logic [TAG_W-1:0]  pri_wtag, alt_wtag;
    logic [DATA_W-1:0] pri_wdata, alt_wdata;
    line_src_e         pri_src, alt_src;
    rsel_e             rsel;
    logic              sel_alt;
    logic              probe_valid;
    logic [TAG_W-1:0]  probe_tag;
    logic              probe_hit;

    pa_index_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_map (
        .addr    (cpu_addr),
        .pri_idx (pri_idx),
        .alt_idx (alt_idx),
        .req_tag (req_tag)
    );

    pa_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_idx    (pri_idx),
        .alt_idx    (alt_idx),
        .pri_valid  (pri_valid),
        .pri_tag    (pri_tag),
        .pri_data   (pri_data),
        .alt_valid  (alt_valid),
        .alt_tag    (alt_tag),
        .alt_data   (alt_data),
        .pri_we     (pri_we),
        .pri_wvalid (pri_wvalid),
        .pri_wtag   (pri_wtag),
        .pri_wdata  (pri_wdata),
        .alt_we     (alt_we),
        .alt_wvalid (alt_wvalid),
        .alt_wtag   (alt_wtag),
        .alt_wdata  (alt_wdata)
    );

    // Single comparator, steered to whichever slot the current probe targets.
    assign probe_valid = sel_alt ? alt_valid : pri_valid;
    assign probe_tag   = sel_alt ? alt_tag   : pri_tag;
    assign probe_hit   = probe_valid && (probe_tag == req_tag);

    pa_probe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .probe_hit (probe_hit),
        .pri_valid (pri_valid),
        .mem_ack   (mem_ack),
        .sel_alt   (sel_alt),
        .cpu_ready (cpu_ready),
        .rsel      (rsel),
        .pri_we    (pri_we),
        .pri_src   (pri_src),
        .alt_we    (alt_we),
        .alt_src   (alt_src),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    always_comb begin
        case (pri_src)
            LSRC_CPU: begin pri_wvalid = 1'b1;      pri_wtag = req_tag; pri_wdata = cpu_wdata; end
            LSRC_MEM: begin pri_wvalid = 1'b1;      pri_wtag = req_tag; pri_wdata = mem_rdata; end
            LSRC_ALT: begin pri_wvalid = alt_valid; pri_wtag = alt_tag; pri_wdata = alt_data;  end
            default:  begin pri_wvalid = pri_valid; pri_wtag = pri_tag; pri_wdata = pri_data;  end
        endcase
    end

    always_comb begin
        case (alt_src)
            LSRC_CPU: begin alt_wvalid = 1'b1;      alt_wtag = req_tag; alt_wdata = cpu_wdata; end
            LSRC_PRI: begin alt_wvalid = pri_valid; alt_wtag = pri_tag; alt_wdata = pri_data;  end
            LSRC_MEM: begin alt_wvalid = 1'b1;      alt_wtag = req_tag; alt_wdata = mem_rdata; end
            default:  begin alt_wvalid = alt_valid; alt_wtag = alt_tag; alt_wdata = alt_data;  end
        endcase
    end

    always_comb begin
        case (rsel)
            RSEL_ALT: cpu_rdata = alt_data;
            RSEL_MEM: cpu_rdata = mem_rdata;
            default:  cpu_rdata = pri_data;
        endcase
    end

    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/pa_cache_chk.sv
module pa_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_ready,
    input logic mem_req,
    input logic mem_we,
    input logic mem_ack
);
    // Cycles elapsed in the current request (0 in its first cycle), saturating.
    logic [7:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)                   age <= 8'd0;
        else if (!cpu_req || cpu_ready) age <= 8'd0;
        else if (age != 8'hFF)        age <= age + 8'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_ready && !mem_req)); // R1

    AST_FAST_HIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we && !mem_ack) |-> (age <= 8'd1)); // R3

    AST_FETCH_AFTER_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> (cpu_req && age >= 8'd2)); // R5

    AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_req && !mem_we) |-> cpu_ready); // R5

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack)); // R8

    AST_NO_WRITE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cpu_we) |-> mem_we); // R10
endmodule

bind pa_cache pa_cache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack)
);

// File: tb/pa_cache_test.sv
`timescale 1ns/1ps
module pa_cache_test;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int LAT = 3;
    localparam int FULL_MISS = 2 + 1 + LAT;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int rd_cnt, wr_cnt, lat_cnt;

    logic [DW-1:0]      mem_q [1<<AW];
    logic [(1<<AW)-1:0] wflag;

    always #2 clk = ~clk;

    pa_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return ({20'd0, a} * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    // Lower-level memory: acknowledges LAT cycles after a request appears.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            rd_cnt    <= 0;
            wr_cnt    <= 0;
            wflag     <= '0;
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == LAT - 1) begin
                mem_ack   <= 1'b1;
                lat_cnt   <= 0;
                mem_rdata <= wflag[mem_addr] ? mem_q[mem_addr] : init_word(mem_addr);
                if (mem_we) begin
                    mem_q[mem_addr] <= mem_wdata;
                    wflag[mem_addr] <= 1'b1;
                    wr_cnt          <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 1;
        #1;
        while (!cpu_ready && lat < 60) begin
            @(negedge clk);
            #1;
            lat++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input int exp_lat,
                          input logic [DW-1:0] exp_data, input int exp_reads);
        logic [DW-1:0] d;
        int lat, r0;
        r0 = rd_cnt;
        access(1'b0, a, '0, d, lat);
        check(req, $sformatf("read %0h latency", a), lat, exp_lat);
        check(req, $sformatf("read %0h data", a), d, exp_data);
        check(req, $sformatf("read %0h memory reads", a), rd_cnt - r0, exp_reads);
    endtask

    task automatic wr_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] v, input int exp_lat);
        logic [DW-1:0] d;
        int lat, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b1, a, v, d, lat);
        check(req, $sformatf("write %0h latency", a), lat, exp_lat);
        check(req, $sformatf("write %0h memory writes", a), wr_cnt - w0, 1);
        check(req, $sformatf("write %0h memory reads", a), rd_cnt - r0, 0);
    endtask

    // Address layout: low 4 bits index, index bit 3 selects the pseudo-set half.
    localparam logic [AW-1:0] A = 12'h053, B = 12'h0A3, G = 12'h0C3, H = 12'h05B;
    localparam logic [AW-1:0] E = 12'h07D, F = 12'h025, W = 12'h3F7;

    task automatic t_reset();
        check("R1", "cpu_ready in reset", cpu_ready, 0);
        check("R1", "mem_req in reset", mem_req, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cpu_ready after reset", cpu_ready, 0);
        check("R1", "mem_req after reset", mem_req, 0);
    endtask

    task automatic t_cold_and_hit();
        rd_chk("R1", A, FULL_MISS, init_word(A), 1);   // R5 latency and fetch too
        rd_chk("R2", A, 1, init_word(A), 0);
    endtask

    task automatic t_pseudo_swap();
        rd_chk("R5", B, FULL_MISS, init_word(B), 1);   // B primary, A to partner
        rd_chk("R3", A, 2, init_word(A), 0);           // slow hit, swap
        rd_chk("R4", A, 1, init_word(A), 0);
    endtask

    task automatic t_evict();
        rd_chk("R6", G, FULL_MISS, init_word(G), 1);   // G in, A to partner, B out
        rd_chk("R6", A, 2, init_word(A), 0);
        rd_chk("R6", B, FULL_MISS, init_word(B), 1);
    endtask

    task automatic t_msb_tag();
        rd_chk("R7", H, FULL_MISS, init_word(H), 1);   // line 11 held A: same upper bits
    endtask

    task automatic t_invalid_primary();
        rd_chk("R6", E, FULL_MISS, init_word(E), 1);
        rd_chk("R6", F, FULL_MISS, init_word(F), 1);
        rd_chk("R6", E, 1, init_word(E), 0);           // partner untouched
    endtask

    task automatic t_write_primary();
        wr_chk("R8", E, 32'hDEADBEEF, 2 + LAT);
        rd_chk("R8", E, 1, 32'hDEADBEEF, 0);
    endtask

    task automatic t_write_alt();
        rd_chk("R9", G, FULL_MISS, init_word(G), 1);   // A moves to partner
        wr_chk("R9", A, 32'h0BADF00D, FULL_MISS);
        rd_chk("R9", A, 2, 32'h0BADF00D, 0);
    endtask

    task automatic t_write_miss();
        wr_chk("R10", W, 32'h13572468, FULL_MISS);
        rd_chk("R10", W, FULL_MISS, 32'h13572468, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (4) @(posedge clk);
        t_reset();
        t_cold_and_hit();
        t_pseudo_swap();
        t_evict();
        t_msb_tag();
        t_invalid_primary();
        t_write_primary();
        t_write_alt();
        t_write_miss();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule